// File: doc/BRIEF.md
# Carry-Save Clock Divider with Serial Shifter

This block derives a slow square-wave clock from a fast system clock and uses that slow clock to pace a small parallel-in, serial-out shifter. The count register is split into a low part and a high part. The carry out of the low part is held in a one-bit register and added into the high part one cycle later. No adder chain therefore spans the full counter width, and the longest path stays inside one part.

The division ratio is set by two part values, worked out off-chip. The combined value is N = part_hi * 2^LO_W + part_lo. The terminal state is recognised as that pair, with no pending carry. It is not decoded as a single binary number.

The generated clock toggles at every terminal state, so each half of its period lasts N + 1 input clocks. The serial line moves to its next bit only when the generated clock rises. A receiver that latches on the falling edge therefore sees data that has been stable for a full half period.

Top module: `csc_clkdiv`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, div_clk and ser_data are both 0. After reset is released, the first rising edge of div_clk comes N + 1 input clocks after the last clock edge that had reset high.
- R2: The combined value is N = part_hi * 2^LO_W + part_lo. Valid pairs have part_lo nonzero unless both parts are zero. Every high phase and every low phase of div_clk lasts exactly N + 1 input clocks.
- R3: The low part advances on every input clock. When it wraps, the carry is held for one cycle and then added into the high part. Division stays exact for counts whose terminal state lies beyond one or more low-part wraps.
- R4: With both part values at zero, div_clk toggles on every input clock.
- R5: When load_en is high at a clock edge, load_word is copied into the shifter. From that edge on, ser_data shows bit DATA_W-1 of the word.
- R6: At each clock edge where div_clk goes from 0 to 1 and no load occurs, the shifter moves one place toward its top bit and a 0 enters at the bottom. ser_data then shows the next lower bit of the word. Once all bits have been sent, 0 follows.
- R7: ser_data changes only at edges where div_clk rises or a load occurs. It is therefore unchanged across every falling edge of div_clk.
- R8: When a load and a rising edge of div_clk fall on the same clock edge, the load takes priority. ser_data then shows bit DATA_W-1 of the new word.
- R9: part_lo = 4 with part_hi = 0 divides the input clock by 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| part_lo | input | LO_W | Low part of the terminal count |
| part_hi | input | HI_W | High part of the terminal count |
| load_word | input | DATA_W | Parallel word for the shifter |
| load_en | input | 1 | Load strobe, one clock wide |
| div_clk | output | 1 | Divided square-wave clock |
| ser_data | output | 1 | Serial data, top bit first |

## Verification
The divider is exercised with several part pairs:
- small counts that never wrap the low part;
- the 10:1 case;
- counts whose terminal state sits just after one or several low-part wraps;
- a maximal pair;
- the all-zero pair.

Comparing the measured intervals across these pairs separates a wrong carry delay or a wrong part weighting from a simple off-by-one in the terminal match. The shifter is tried with three patterns:
- a load placed well away from any rising edge, which checks bit order and zero fill;
- a load placed on the same edge as a rise, which checks priority;
- a reset issued mid-stream, which checks that the shifter clears and that counting restarts.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int unsigned CSD_LO_W_DEF   = 4;
    localparam int unsigned CSD_HI_W_DEF   = 4;
    localparam int unsigned CSD_DATA_W_DEF = 8;

    // Action taken by the shifter at a clock edge
    typedef enum logic [1:0] {
        SH_HOLD  = 2'd0,
        SH_LOAD  = 2'd1,
        SH_SHIFT = 2'd2
    } sh_op_e;

    // Load outranks a shift that falls on the same edge
    function automatic sh_op_e pick_op(input logic load, input logic rise);
        if (load) return SH_LOAD;
        if (rise) return SH_SHIFT;
        return SH_HOLD;
    endfunction

endpackage

// File: rtl/csd_split_counter.sv
module csd_split_counter #(
    parameter int unsigned LO_W = csd_pkg::CSD_LO_W_DEF,
    parameter int unsigned HI_W = csd_pkg::CSD_HI_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LO_W-1:0] part_lo,
    input  logic [HI_W-1:0] part_hi,
    output logic            term
);

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic            carry;
        logic [LO_W-1:0] lo;
    } cnt_t;

    cnt_t cur;
    cnt_t nxt;
    logic lo_full;
    logic at_term;

    assign lo_full = &cur.lo;
    // Terminal state: both parts match and no carry is still pending
    assign at_term = !cur.carry && (cur.lo == part_lo) && (cur.hi == part_hi);

    always_comb begin
        nxt = '0;
        if (!at_term) begin
            nxt.lo    = cur.lo + 1'b1;
            nxt.carry = lo_full;
            nxt.hi    = cur.hi + HI_W'(cur.carry);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign term = at_term;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (cur == '0));

    p_carry_saved_r3: assert property (@(posedge clk) disable iff (rst)
        (lo_full && !at_term) |=> (cur.carry && cur.lo == '0));

    p_high_takes_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (cur.carry && !at_term) |=> (cur.hi == $past(cur.hi) + HI_W'(1)));

    p_high_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!cur.carry && !at_term) |=> $stable(cur.hi));

    p_term_clears_r2: assert property (@(posedge clk) disable iff (rst)
        at_term |=> (cur == '0));

endmodule

// File: rtl/csd_toggle_gen.sv
module csd_toggle_gen (
    input  logic clk,
    input  logic rst,
    input  logic term,
    output logic div_clk,
    output logic rise
);

    logic div_q;

    always_ff @(posedge clk) begin
        if (rst)       div_q <= 1'b0;
        else if (term) div_q <= ~div_q;
    end

    // High in the cycle whose closing edge drives the divided clock high
    assign rise    = term && !div_q;
    assign div_clk = div_q;

    p_toggle_on_term_r2: assert property (@(posedge clk) disable iff (rst)
        term |=> (div_q != $past(div_q)));

    p_hold_off_term_r2: assert property (@(posedge clk) disable iff (rst)
        !term |=> $stable(div_q));

    p_rise_goes_high_r6: assert property (@(posedge clk) disable iff (rst)
        rise |=> div_q);

endmodule

// File: rtl/csd_shifter.sv
module csd_shifter #(
    parameter int unsigned DATA_W = csd_pkg::CSD_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic              rise,
    output logic              ser
);
    import csd_pkg::*;

    logic [DATA_W-1:0] sreg;
    sh_op_e            op;

    assign op = pick_op(load, rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else begin
            case (op)
                SH_LOAD:  sreg <= word;
                SH_SHIFT: sreg <= {sreg[DATA_W-2:0], 1'b0};
                default:  sreg <= sreg;
            endcase
        end
    end

    assign ser = sreg[DATA_W-1];

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && !rise) |=> $stable(sreg));

    p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (sreg == $past(word)));

    p_shift_r6: assert property (@(posedge clk) disable iff (rst)
        (rise && !load) |=> (sreg == {$past(sreg[DATA_W-2:0]), 1'b0}));

endmodule

// File: rtl/csc_clkdiv.sv
module csc_clkdiv #(
    parameter int unsigned LO_W   = csd_pkg::CSD_LO_W_DEF,
    parameter int unsigned HI_W   = csd_pkg::CSD_HI_W_DEF,
    parameter int unsigned DATA_W = csd_pkg::CSD_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LO_W-1:0]   part_lo,
    input  logic [HI_W-1:0]   part_hi,
    input  logic [DATA_W-1:0] load_word,
    input  logic              load_en,
    output logic              div_clk,
    output logic              ser_data
);

    logic term;
    logic rise;

    csd_split_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .part_lo (part_lo),
        .part_hi (part_hi),
        .term    (term)
    );

    csd_toggle_gen u_tog (
        .clk     (clk),
        .rst     (rst),
        .term    (term),
        .div_clk (div_clk),
        .rise    (rise)
    );

    csd_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .load (load_en),
        .word (load_word),
        .rise (rise),
        .ser  (ser_data)
    );

    p_reset_outputs_r1: assert property (@(posedge clk)
        rst |=> (!div_clk && !ser_data));

    p_ser_only_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !rise) |=> $stable(ser_data));

endmodule

// File: tb/test_csc_clkdiv.sv
`timescale 1ns/1ps
module test_csc_clkdiv;

    localparam int LO_W   = 4;
    localparam int HI_W   = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [LO_W-1:0]   part_lo = '0;
    logic [HI_W-1:0]   part_hi = '0;
    logic [DATA_W-1:0] load_word = '0;
    logic              load_en = 1'b0;
    logic              div_clk;
    logic              ser_data;

    always #2.5 clk = ~clk;

    csc_clkdiv #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)) i_csc_clkdiv (
        .clk       (clk),
        .rst       (rst),
        .part_lo   (part_lo),
        .part_hi   (part_hi),
        .load_word (load_word),
        .load_en   (load_en),
        .div_clk   (div_clk),
        .ser_data  (ser_data)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    int    half_q[$];
    string half_tag[$];
    int    bit_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: interval between div_clk changes, compared with the queue
    int   cyc = 0;
    logic prev_div = 1'b0;
    initial forever begin
        int    e;
        string t;
        @(posedge clk); #1;
        if (rst) begin
            cyc = 0;
            prev_div = div_clk;
        end else begin
            cyc++;
            if (div_clk !== prev_div) begin
                if (half_q.size() > 0) begin
                    e = half_q.pop_front();
                    t = half_tag.pop_front();
                    check(cyc == e, t, cyc, e);
                end
                cyc = 0;
                prev_div = div_clk;
            end
        end
    end

    // Monitor: serial bits at rises, stability elsewhere
    logic prev_ser = 1'b0;
    logic sprev_div = 1'b0;
    initial forever begin
        logic rose;
        int   e;
        @(posedge clk); #1;
        if (!rst) begin
            rose = div_clk && !sprev_div;
            if (rose && bit_q.size() > 0) begin
                e = bit_q.pop_front();
                check(int'(ser_data) == e, "R6 bit after rise", int'(ser_data), e);
            end else if (!rose && !load_en) begin
                check(ser_data === prev_ser, "R7 no change off rise", int'(ser_data), int'(prev_ser));
            end
        end
        prev_ser  = ser_data;
        sprev_div = div_clk;
    end

    task automatic run_config(input int lo, input int hi, input int ntog, input string tag);
        int h;
        h = hi * (1 << LO_W) + lo + 1;
        @(negedge clk);
        rst = 1'b1;
        part_lo = LO_W'(lo);
        part_hi = HI_W'(hi);
        for (int k = 0; k < ntog; k++) begin
            half_q.push_back(h);
            half_tag.push_back(tag);
        end
        @(negedge clk);
        rst = 1'b0;
        while (half_q.size() != 0) @(posedge clk);
    endtask

    task automatic wait_div(input logic v);
        do begin
            @(posedge clk); #1;
        end while (div_clk !== v);
    endtask

    task automatic push_bits(input logic [DATA_W-1:0] w, input int fill);
        for (int b = DATA_W - 2; b >= 0; b--) bit_q.push_back(int'(w[b]));
        for (int f = 0; f < fill; f++) bit_q.push_back(0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(div_clk === 1'b0, "R1 div_clk in reset", int'(div_clk), 0);
        check(ser_data === 1'b0, "R1 ser_data in reset", int'(ser_data), 0);

        run_config(4, 0, 4, "R9 divide by ten");
        run_config(3, 0, 4, "R2 small count");
        run_config(1, 0, 4, "R2 count one");
        run_config(0, 0, 6, "R4 zero pair");
        run_config(15, 1, 3, "R3 one wrap");
        run_config(1, 3, 3, "R3 just after wrap");
        run_config(9, 2, 3, "R2 mixed parts");
        run_config(15, 15, 2, "R2 maximal pair");

        // Shifter: load away from any rise (half period 3)
        run_config(2, 0, 1, "R1 first rise after release");
        wait_div(1'b0);
        wait_div(1'b1);
        @(negedge clk);
        load_word = 8'hB4;
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        check(ser_data === 1'b1, "R5 top bit after load", int'(ser_data), 1);
        push_bits(8'hB4, 2);
        while (bit_q.size() != 0) @(posedge clk);

        // Load on the same edge as a rise
        wait_div(1'b1);
        wait_div(1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        load_word = 8'hC3;
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        check(div_clk === 1'b1, "R8 rise coincides with load", int'(div_clk), 1);
        check(ser_data === 1'b1, "R8 load wins over shift", int'(ser_data), 1);
        push_bits(8'hC3, 1);
        while (bit_q.size() != 0) @(posedge clk);

        // Reset mid-stream
        @(negedge clk);
        load_word = 8'hFF;
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        wait_div(1'b1);
        @(negedge clk);
        rst = 1'b1;
        half_q.push_back(3);
        half_tag.push_back("R1 restart after reset");
        @(posedge clk); #1;
        check(div_clk === 1'b0, "R1 div_clk cleared", int'(div_clk), 0);
        check(ser_data === 1'b0, "R1 shifter cleared", int'(ser_data), 0);
        @(negedge clk);
        rst = 1'b0;
        while (half_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule